// File: doc/BRIEF.md
# Interrupt and DMA Request Routing Switch

This block connects the request lines of a single local function to a shared expansion bus. Each of two local interrupt requests can go to any one of eight bus interrupt lines. One local DMA request can go to either of two bus DMA request lines. The acknowledge of the chosen bus channel is passed back to the local function.

Every bus interrupt line has its own drive type. A totem-pole line always drives its level. An open-drain line only ever pulls low, so several cards can share one bus line. Pads are not modelled: each bus interrupt line appears as a value plus an output enable.

A mode setting picks how the local pins are used:
- In DMA mode, the highest-numbered local interrupt input is given up to the DMA function, and the DMA path is live.
- In extended interrupt mode, every local interrupt input is routable and the DMA path is idle.

Configuration is captured in registers on each rising clock edge. From the local request pins to the bus lines the path is purely combinational.

Top module: `irq_dma_router`

## Requirements
- R1: While `rstN` is low, and after it, until new configuration is captured, all routing is off. Every bus interrupt line is totem-pole and unrouted (`busIrqOe` all ones, `busIrqVal` all zeros), `busDrq` is zero and `localDack` is zero.
- R2: The configuration inputs are registered on the rising clock edge and take effect from that edge on. The request and acknowledge inputs reach the outputs combinationally, within the same cycle.
- R3: An enabled local interrupt `s` routes to the bus line whose index is `cfgIrqSel[s*3 +: 3]`. When two routed sources share one bus line, the line level is the OR of both.
- R4: A bus interrupt line whose `cfgOpenDrain` bit is 0 (totem-pole) always has `busIrqOe` at 1. Its `busIrqVal` equals its routed level, and is 0 when nothing is routed to it.
- R5: A bus interrupt line whose `cfgOpenDrain` bit is 1 (open-drain) always has `busIrqVal` at 0. Its `busIrqOe` is 1 only when a source is routed to it and the routed level is low; it floats when the request is active or nothing is routed to it.
- R6: `cfgMode` = 0 selects DMA mode, in which the highest-numbered local interrupt input is never routed. `cfgMode` = 1 selects extended interrupt mode, in which `busDrq` and `localDack` are held at 0.
- R7: In DMA mode with `cfgDmaEn` = 1, `busDrq[cfgDmaSel]` follows `localDrq` and the other request line stays 0. Otherwise both lines are 0.
- R8: In DMA mode with `cfgDmaEn` = 1, `localDack` follows `busDack[cfgDmaSel]`, and the acknowledge of the other channel has no effect. Otherwise `localDack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgMode | input | 1 | 0 = DMA mode, 1 = extended interrupt mode |
| cfgIrqEn | input | 2 | Enable per local interrupt input |
| cfgIrqSel | input | 6 | Bus line index per local input, 3 bits each |
| cfgOpenDrain | input | 8 | Drive type per bus interrupt line, 1 = open-drain |
| cfgDmaEn | input | 1 | Enables the DMA path |
| cfgDmaSel | input | 1 | Selected bus DMA channel |
| localIrq | input | 2 | Local interrupt requests, active high |
| localDrq | input | 1 | Local DMA request, active high |
| busDack | input | 2 | Bus DMA acknowledges, active high |
| busIrqVal | output | 8 | Driven value of each bus interrupt line |
| busIrqOe | output | 8 | Output enable of each bus interrupt line |
| busDrq | output | 2 | Bus DMA requests, active high |
| localDack | output | 1 | Local DMA acknowledge, active high |

## Verification
The assertions compare outputs against the configuration sampled one edge earlier. They therefore assume that the configuration inputs are steady across each rising edge, and they only apply once reset has been released for a full cycle. The stimulus changes every input two time units after the rising edge and never near the edge itself. Reset is released in the same way.

The assertions also assume that the two bus acknowledges may be high together. The random phase lets that happen, so the one-channel acknowledge rule is exercised under overlap.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int IRQ_IN_N  = 2;
  localparam int IRQ_OUT_N = 8;
  localparam int DMA_CH_N  = 2;
  localparam int IRQ_SEL_W = (IRQ_OUT_N > 1) ? $clog2(IRQ_OUT_N) : 1;
  localparam int DMA_SEL_W = (DMA_CH_N > 1) ? $clog2(DMA_CH_N) : 1;

  typedef enum logic {
    MODE_DMA     = 1'b0,
    MODE_EXT_IRQ = 1'b1
  } busMode_e;

  typedef struct packed {
    busMode_e                               mode;
    logic [IRQ_IN_N-1:0]                    irqEn;
    logic [IRQ_IN_N-1:0][IRQ_SEL_W-1:0]     irqSel;
    logic [IRQ_OUT_N-1:0]                   openDrain;
    logic                                   dmaEn;
    logic [DMA_SEL_W-1:0]                   dmaSel;
  } routeCfg_t;

  typedef struct packed {
    logic [IRQ_IN_N-1:0][IRQ_OUT_N-1:0] route;
    logic [IRQ_OUT_N-1:0]               openDrain;
    logic [DMA_CH_N-1:0]                dmaCh;
  } routeStrobe_t;
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  routeCfg_t    cfgIn,
  output routeStrobe_t strobe
);
  routeCfg_t cfgQ;
  logic [IRQ_IN_N-1:0][IRQ_OUT_N-1:0] routeMask;
  logic [DMA_CH_N-1:0] dmaMask;
  logic dmaLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgIn;
  end

  for (genvar s = 0; s < IRQ_IN_N; s++) begin : g_src
    logic srcLive;
    if (s == IRQ_IN_N - 1) begin : g_shared
      // last input doubles as the DMA request pin in DMA mode
      assign srcLive = cfgQ.irqEn[s] && (cfgQ.mode == MODE_EXT_IRQ);
    end else begin : g_plain
      assign srcLive = cfgQ.irqEn[s];
    end
    always_comb begin
      routeMask[s] = '0;
      for (int o = 0; o < IRQ_OUT_N; o++) begin
        if (srcLive && (cfgQ.irqSel[s] == IRQ_SEL_W'(o))) routeMask[s][o] = 1'b1;
      end
    end
  end

  assign dmaLive = cfgQ.dmaEn && (cfgQ.mode == MODE_DMA);

  for (genvar c = 0; c < DMA_CH_N; c++) begin : g_ch
    assign dmaMask[c] = dmaLive && (cfgQ.dmaSel == DMA_SEL_W'(c));
  end

  assign strobe = '{route: routeMask, openDrain: cfgQ.openDrain, dmaCh: dmaMask};
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
(
  input  routeStrobe_t         strobe,
  input  logic [IRQ_IN_N-1:0]  localIrq,
  input  logic                 localDrq,
  input  logic [DMA_CH_N-1:0]  busDack,
  output logic [IRQ_OUT_N-1:0] busIrqVal,
  output logic [IRQ_OUT_N-1:0] busIrqOe,
  output logic [DMA_CH_N-1:0]  busDrq,
  output logic                 localDack
);
  for (genvar o = 0; o < IRQ_OUT_N; o++) begin : g_out
    logic level;
    logic routed;
    always_comb begin
      level  = 1'b0;
      routed = 1'b0;
      for (int s = 0; s < IRQ_IN_N; s++) begin
        routed = routed | strobe.route[s][o];
        level  = level | (strobe.route[s][o] & localIrq[s]);
      end
    end
    // open-drain: only pull low for an idle routed request, else release
    assign busIrqVal[o] = strobe.openDrain[o] ? 1'b0 : level;
    assign busIrqOe[o]  = strobe.openDrain[o] ? (routed & ~level) : 1'b1;
  end

  assign busDrq    = strobe.dmaCh & {DMA_CH_N{localDrq}};
  assign localDack = |(strobe.dmaCh & busDack);
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
  import irq_route_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgMode,
  input  logic [IRQ_IN_N-1:0]           cfgIrqEn,
  input  logic [IRQ_IN_N*IRQ_SEL_W-1:0] cfgIrqSel,
  input  logic [IRQ_OUT_N-1:0]          cfgOpenDrain,
  input  logic                          cfgDmaEn,
  input  logic [DMA_SEL_W-1:0]          cfgDmaSel,
  input  logic [IRQ_IN_N-1:0]           localIrq,
  input  logic                          localDrq,
  input  logic [DMA_CH_N-1:0]           busDack,
  output logic [IRQ_OUT_N-1:0]          busIrqVal,
  output logic [IRQ_OUT_N-1:0]          busIrqOe,
  output logic [DMA_CH_N-1:0]           busDrq,
  output logic                          localDack
);
  routeCfg_t    cfgIn;
  routeStrobe_t strobe;

  always_comb begin
    cfgIn.mode      = busMode_e'(cfgMode);
    cfgIn.irqEn     = cfgIrqEn;
    cfgIn.openDrain = cfgOpenDrain;
    cfgIn.dmaEn     = cfgDmaEn;
    cfgIn.dmaSel    = cfgDmaSel;
    for (int s = 0; s < IRQ_IN_N; s++) cfgIn.irqSel[s] = cfgIrqSel[s*IRQ_SEL_W +: IRQ_SEL_W];
  end

  irq_route_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgIn  (cfgIn),
    .strobe (strobe)
  );

  irq_route_dp i_dp (
    .strobe    (strobe),
    .localIrq  (localIrq),
    .localDrq  (localDrq),
    .busDack   (busDack),
    .busIrqVal (busIrqVal),
    .busIrqOe  (busIrqOe),
    .busDrq    (busDrq),
    .localDack (localDack)
  );
endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk
  import irq_route_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgMode,
  input logic [IRQ_OUT_N-1:0] cfgOpenDrain,
  input logic                 cfgDmaEn,
  input logic [DMA_SEL_W-1:0] cfgDmaSel,
  input logic                 localDrq,
  input logic [DMA_CH_N-1:0]  busDack,
  input logic [IRQ_OUT_N-1:0] busIrqVal,
  input logic [IRQ_OUT_N-1:0] busIrqOe,
  input logic [DMA_CH_N-1:0]  busDrq,
  input logic                 localDack
);
  // R5: an open-drain line never drives a high level
  a_r5_od_never_high: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((busIrqVal & busIrqOe & $past(cfgOpenDrain)) == '0));

  // R4: a totem-pole line is always driven
  a_r4_totem_driven: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((busIrqOe | $past(cfgOpenDrain)) == '1));

  // R7: at most one bus request line, and only for a live local request
  a_r7_drq_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busDrq) && ((busDrq == '0) || localDrq));

  // R6: extended interrupt mode keeps the DMA path idle
  a_r6_ext_no_dma: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cfgMode)) |-> (busDrq == '0 && !localDack));

  // R8: the local acknowledge needs an enabled path and the chosen channel's ack
  a_r8_dack_selected: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && localDack) |-> ($past(cfgDmaEn) && busDack[$past(cfgDmaSel)]));
endmodule

bind irq_dma_router irq_dma_router_chk i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgMode      (cfgMode),
  .cfgOpenDrain (cfgOpenDrain),
  .cfgDmaEn     (cfgDmaEn),
  .cfgDmaSel    (cfgDmaSel),
  .localDrq     (localDrq),
  .busDack      (busDack),
  .busIrqVal    (busIrqVal),
  .busIrqOe     (busIrqOe),
  .busDrq       (busDrq),
  .localDack    (localDack)
);

// File: tb/test_irq_dma_router.sv
`timescale 1ns/1ps
module test_irq_dma_router;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMode = 1'b0;
  logic [1:0] cfgIrqEn = '0;
  logic [5:0] cfgIrqSel = '0;
  logic [7:0] cfgOpenDrain = '0;
  logic cfgDmaEn = 1'b0;
  logic cfgDmaSel = 1'b0;
  logic [1:0] localIrq = '0;
  logic localDrq = 1'b0;
  logic [1:0] busDack = '0;
  logic [7:0] busIrqVal, busIrqOe;
  logic [1:0] busDrq;
  logic localDack;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit finished = 0;
  string curTag = "R1";

  // model copy of the captured configuration
  bit mMode, mDmaEn, mDmaSel;
  bit [1:0] mIrqEn;
  int mSel [2];
  bit [7:0] mOd;

  always #5 clk = ~clk;

  irq_dma_router i_irq_dma_router (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgIrqEn(cfgIrqEn),
    .cfgIrqSel(cfgIrqSel), .cfgOpenDrain(cfgOpenDrain), .cfgDmaEn(cfgDmaEn),
    .cfgDmaSel(cfgDmaSel), .localIrq(localIrq), .localDrq(localDrq),
    .busDack(busDack), .busIrqVal(busIrqVal), .busIrqOe(busIrqOe),
    .busDrq(busDrq), .localDack(localDack)
  );

  // R2: configuration is taken at the rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode <= 0; mDmaEn <= 0; mDmaSel <= 0; mIrqEn <= 0; mOd <= 0;
      mSel[0] <= 0; mSel[1] <= 0;
    end else begin
      mMode <= cfgMode; mDmaEn <= cfgDmaEn; mDmaSel <= cfgDmaSel;
      mIrqEn <= cfgIrqEn; mOd <= cfgOpenDrain;
      mSel[0] <= int'(cfgIrqSel[2:0]); mSel[1] <= int'(cfgIrqSel[5:3]);
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      bit [7:0] eVal, eOe;
      bit [1:0] eDrq;
      bit eDack;
      string tag;
      tag = rstN ? curTag : "R1";
      for (int o = 0; o < 8; o++) begin
        bit lvl, hit;
        lvl = 0; hit = 0;
        for (int s = 0; s < 2; s++) begin
          if (mIrqEn[s] && (mMode || s == 0) && mSel[s] == o) begin
            hit = 1;
            if (localIrq[s]) lvl = 1;
          end
        end
        if (mOd[o]) begin eVal[o] = 0; eOe[o] = hit && !lvl; end
        else begin eVal[o] = lvl; eOe[o] = 1; end
      end
      eDrq = 0; eDack = 0;
      if (!mMode && mDmaEn) begin
        eDrq[mDmaSel] = localDrq;
        eDack = busDack[mDmaSel];
      end
      check(tag, "busIrqVal", int'(busIrqVal), int'(eVal));
      check(tag, "busIrqOe", int'(busIrqOe), int'(eOe));
      check(tag, "busDrq", int'(busDrq), int'(eDrq));
      check(tag, "localDack", int'(localDack), int'(eDack));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic setIrq(bit mode, bit [1:0] en, int s0, int s1, bit [7:0] od);
    cfgMode = mode; cfgIrqEn = en; cfgOpenDrain = od;
    cfgIrqSel = {3'(s1), 3'(s0)};
  endtask

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with busy inputs that must not leak
    curTag = "R1";
    setIrq(1, 2'b11, 3, 4, 8'hF0);
    localIrq = 2'b11; localDrq = 1; busDack = 2'b11;
    @(posedge clk); #2; started = 1;
    tick(3);
    rstN = 1;
    tick(1);

    // R3: two sources on separate lines, then OR-ed on one line
    curTag = "R3";
    setIrq(1, 2'b11, 5, 2, 8'h00);
    localIrq = 0;
    tick(1);
    localIrq = 2'b01; tick(1);
    localIrq = 2'b10; tick(1);
    localIrq = 2'b11; tick(1);
    setIrq(1, 2'b11, 6, 6, 8'h00);
    localIrq = 2'b00; tick(1);
    localIrq = 2'b10; tick(1);
    localIrq = 2'b01; tick(1);

    // R2: a change of routing is seen from the next edge only
    curTag = "R2";
    localIrq = 2'b01;
    setIrq(1, 2'b01, 1, 0, 8'h00);
    #1;
    check("R2", "busIrqVal before edge", int'(busIrqVal), 8'h40);
    tick(1);
    check("R2", "busIrqVal after edge", int'(busIrqVal), 8'h02);
    localIrq = 2'b00; #1;
    check("R2", "busIrqVal same-cycle input", int'(busIrqVal), 8'h00);
    tick(1);

    // R4 and R5: mixed drive types
    curTag = "R5";
    setIrq(1, 2'b11, 3, 7, 8'b1000_1010);
    localIrq = 2'b00; tick(1);
    localIrq = 2'b01; tick(1);
    localIrq = 2'b10; tick(1);
    localIrq = 2'b11; tick(1);
    curTag = "R4";
    setIrq(1, 2'b11, 3, 7, 8'h00);
    tick(1);
    localIrq = 2'b00; tick(1);

    // R6: DMA mode drops the last interrupt input
    curTag = "R6";
    setIrq(0, 2'b11, 0, 4, 8'h10);
    cfgDmaEn = 0;
    localIrq = 2'b10; tick(1);
    localIrq = 2'b11; tick(1);
    setIrq(1, 2'b11, 0, 4, 8'h10);
    cfgDmaEn = 1; localDrq = 1; busDack = 2'b11;
    tick(2);

    // R7 and R8: each channel, with the unselected ack toggling
    curTag = "R7";
    setIrq(0, 2'b01, 2, 0, 8'h00);
    cfgDmaEn = 1; cfgDmaSel = 0;
    localDrq = 0; busDack = 0; tick(1);
    localDrq = 1; tick(1);
    cfgDmaSel = 1; tick(1);
    localDrq = 0; tick(1);
    curTag = "R8";
    busDack = 2'b01; tick(1);
    busDack = 2'b10; tick(1);
    cfgDmaSel = 0; tick(1);
    busDack = 2'b01; tick(1);
    cfgDmaEn = 0; localDrq = 1; busDack = 2'b11; tick(2);

    // mixed sweep
    curTag = "R3";
    for (int i = 0; i < 400; i++) begin
      if (i % 4 == 0) begin
        cfgMode = 1'($urandom); cfgIrqEn = 2'($urandom);
        cfgIrqSel = 6'($urandom); cfgOpenDrain = 8'($urandom);
        cfgDmaEn = 1'($urandom); cfgDmaSel = 1'($urandom);
      end
      localIrq = 2'($urandom); localDrq = 1'($urandom); busDack = 2'($urandom);
      tick(1);
    end

    // R1 again: reset mid-run clears routing
    curTag = "R1";
    rstN = 0; tick(2);
    rstN = 1; tick(1);
    @(posedge clk); #1;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule